// File: doc/BRIEF.md
# Serial Hit Receiver with Event Rollback Buffer

This block takes one serial hit stream from a front-end readout chip and sits at the front of an event-building channel. The line rests low. A single high bit announces a record. The receiver then shifts in a fixed number of payload bits, MSB first, and turns them into one 25-bit word. Each word is written into a 32-slot ring buffer. A record whose row and column hold a reserved code marks the end of an event. That record is stored like any other, and a one-cycle end-of-event pulse goes to the downstream scoreboard.

The buffer keeps three ring pointers: write, read, and a shadow pointer to the end of the last complete event. The read side sees words only up to the shadow pointer, so the event builder never reads half an event. If a record arrives while the ring is full, the write pointer is reloaded from the shadow pointer. This throws away the partial event, and a sticky error flag is set. The rest of that event's hits are dropped until its end marker arrives. The marker is then kept, so the scoreboard still counts the event, now empty. Only the event builder moves the read pointer, through its read strobe.

Top module: `hitrx_rollback`

## Requirements
- R1: With the line idle, a high sample on `ser_i` at a rising clock edge starts a record. The next 25 samples, MSB first, are trigger number (4 bits), row (8), column (5), then time-over-threshold (8). They are stored as one word with trigger in [24:21], row in [20:13], column in [12:8] and time-over-threshold in [7:0].
- R2: The header of a new record may come on the clock edge right after the last bit of the previous record, with no idle cycle between them. Both records are received.
- R3: A record with row 255 and column 31 is an end marker. It is stored as a word and closes the event, which becomes readable. `eoe_o` pulses high for exactly one cycle for each marker stored.
- R4: `empty_o` is high when no stored word of a closed event is still unread. Hits of an event whose marker has not arrived are not readable.
- R5: `rd_word_o` shows the oldest unread word of a closed event. With `rd_en_i` high and `empty_o` low, the next rising edge advances to the next word. With `empty_o` high, `rd_en_i` has no effect.
- R6: The ring holds at most 31 words (the number of slots minus one) and wraps modulo 32. Up to 31 words can be stored without any loss or error.
- R7: A record that arrives while 31 words are held is not stored. The open event's words are discarded. The remaining hits of that event are dropped until its end marker, which is then stored alone. If the record that overflows is itself a marker, it is dropped too and no `eoe_o` pulse is given.
- R8: `ovf_err_o` goes high on the first overflow and stays high until reset.
- R9: After reset `empty_o` is high, `eoe_o` and `ovf_err_o` are low, and the ring is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock; serial data sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ser_i | input | 1 | Serial hit stream, idle low |
| rd_en_i | input | 1 | Read strobe from the event builder |
| rd_word_o | output | 25 | Oldest readable word |
| empty_o | output | 1 | No readable word of a closed event |
| eoe_o | output | 1 | One-cycle pulse per end marker stored |
| ovf_err_o | output | 1 | Sticky overflow flag |

## Verification
The bench fills the ring to exactly 31 words. A design whose full test is off by one would either raise the error there or overwrite unread data. It forces overflow in the middle of an event that follows a closed one. A design that rolled back to the wrong pointer would lose the earlier event or hand out part of the truncated one. It also checks that the dropped remainder is not stored and that the marker arrives alone. It sends records back to back with no idle bit, which catches a receiver that needs a cycle to re-arm. It reads while a partial event sits in the ring and while the ring is empty, which catches a read pointer that runs past the shadow pointer.

// File: rtl/hitrx_pkg.sv
package hitrx_pkg;

    localparam int TRIG_W = 4;
    localparam int ROW_W  = 8;
    localparam int COL_W  = 5;
    localparam int TOT_W  = 8;
    localparam int WORD_W = TRIG_W + ROW_W + COL_W + TOT_W;

    localparam logic [ROW_W-1:0] EOE_ROW = '1;
    localparam logic [COL_W-1:0] EOE_COL = '1;

    typedef struct packed {
        logic [TRIG_W-1:0] trig;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [TOT_W-1:0]  tot;
    } hit_word_t;

    typedef enum logic {
        RX_IDLE  = 1'b0,
        RX_SHIFT = 1'b1
    } rx_state_t;

    function automatic logic is_marker(hit_word_t w);
        return (w.row == EOE_ROW) && (w.col == EOE_COL);
    endfunction

endpackage

// File: rtl/hitrx_deser.sv
module hitrx_deser
    import hitrx_pkg::*;
#(
    parameter bit HAS_TOT = 1'b1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      ser_i,
    output logic      rec_valid_o,
    output hit_word_t rec_word_o
);

    localparam int REC_BITS = TRIG_W + ROW_W + COL_W + (HAS_TOT ? TOT_W : 0);
    localparam int CNT_W    = $clog2(REC_BITS);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(REC_BITS - 1);

    rx_state_t          state;
    logic [CNT_W-1:0]   bit_cnt;
    logic [WORD_W-1:0]  shreg;
    logic [WORD_W-1:0]  assembled;
    hit_word_t          packed_word;

    assign assembled = {shreg[WORD_W-2:0], ser_i};

    generate
        if (HAS_TOT) begin : g_with_tot
            assign packed_word = hit_word_t'(assembled);
        end else begin : g_no_tot
            assign packed_word = hit_word_t'({assembled[REC_BITS-1:0], {TOT_W{1'b0}}});
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= RX_IDLE;
            bit_cnt     <= '0;
            shreg       <= '0;
            rec_valid_o <= 1'b0;
            rec_word_o  <= '0;
        end else begin
            rec_valid_o <= 1'b0;
            unique case (state)
                RX_IDLE: begin
                    if (ser_i) begin
                        state   <= RX_SHIFT;
                        bit_cnt <= '0;
                    end
                end
                RX_SHIFT: begin
                    shreg <= assembled;
                    if (bit_cnt == LAST_BIT) begin
                        state       <= RX_IDLE;
                        rec_valid_o <= 1'b1;
                        rec_word_o  <= packed_word;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    // R1
    rec_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rec_valid_o |=> !rec_valid_o);

endmodule

// File: rtl/hitrx_fifo.sv
module hitrx_fifo
    import hitrx_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid_i,
    input  hit_word_t         wr_word_i,
    input  logic              rd_en_i,
    output logic [WORD_W-1:0] rd_word_o,
    output logic              empty_o,
    output logic              eoe_o,
    output logic              ovf_err_o
);

    localparam int PTR_W = $clog2(DEPTH);
    typedef logic [PTR_W-1:0] ptr_t;

    function automatic ptr_t ring_inc(ptr_t p);
        return (p == ptr_t'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    logic [WORD_W-1:0] mem [DEPTH];
    ptr_t wr_ptr, rd_ptr, last_ptr;
    logic dropping, marker, take, full;

    assign marker    = is_marker(wr_word_i);
    assign take      = wr_valid_i && !(dropping && !marker);
    assign full      = (ring_inc(wr_ptr) == rd_ptr);
    assign empty_o   = (rd_ptr == last_ptr);
    assign rd_word_o = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (take && !full) begin
            mem[wr_ptr] <= wr_word_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            last_ptr  <= '0;
            dropping  <= 1'b0;
            eoe_o     <= 1'b0;
            ovf_err_o <= 1'b0;
        end else begin
            eoe_o <= 1'b0;
            if (take) begin
                if (full) begin
                    wr_ptr    <= last_ptr;
                    ovf_err_o <= 1'b1;
                    dropping  <= !marker;
                end else begin
                    wr_ptr   <= ring_inc(wr_ptr);
                    dropping <= 1'b0;
                    if (marker) begin
                        last_ptr <= ring_inc(wr_ptr);
                        eoe_o    <= 1'b1;
                    end
                end
            end
            if (rd_en_i && !empty_o) begin
                rd_ptr <= ring_inc(rd_ptr);
            end
        end
    end

    // R7
    rollback_chk: assert property (@(posedge clk) disable iff (rst)
        (take && full) |=> (wr_ptr == $past(last_ptr)));

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_err_o |=> ovf_err_o);

    // R5
    rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && empty_o) |=> $stable(rd_ptr));

    // R6
    no_overrun_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ptr == rd_ptr) |-> (last_ptr == rd_ptr));

    // R3
    eoe_src_chk: assert property (@(posedge clk) disable iff (rst)
        eoe_o |-> $past(wr_valid_i));

endmodule

// File: rtl/hitrx_rollback.sv
module hitrx_rollback
    import hitrx_pkg::*;
#(
    parameter int DEPTH   = 32,
    parameter bit HAS_TOT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_i,
    input  logic              rd_en_i,
    output logic [WORD_W-1:0] rd_word_o,
    output logic              empty_o,
    output logic              eoe_o,
    output logic              ovf_err_o
);

    logic      rec_valid;
    hit_word_t rec_word;

    hitrx_deser #(
        .HAS_TOT (HAS_TOT)
    ) deser_i (
        .clk         (clk),
        .rst         (rst),
        .ser_i       (ser_i),
        .rec_valid_o (rec_valid),
        .rec_word_o  (rec_word)
    );

    hitrx_fifo #(
        .DEPTH (DEPTH)
    ) fifo_i (
        .clk        (clk),
        .rst        (rst),
        .wr_valid_i (rec_valid),
        .wr_word_i  (rec_word),
        .rd_en_i    (rd_en_i),
        .rd_word_o  (rd_word_o),
        .empty_o    (empty_o),
        .eoe_o      (eoe_o),
        .ovf_err_o  (ovf_err_o)
    );

endmodule

// File: tb/hitrx_rollback_tb.sv
`timescale 1ns/1ps
module hitrx_rollback_tb_top;

    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_i = 1'b0;
    logic        rd_en_i = 1'b0;
    logic [24:0] rd_word_o;
    logic        empty_o, eoe_o, ovf_err_o;

    int checks = 0;
    int failures = 0;
    int eoe_seen = 0;

    logic [24:0] cq[$];
    logic [24:0] pq[$];
    logic        m_drop = 1'b0;
    logic        m_ovf = 1'b0;
    int          m_eoe = 0;

    always #2.5 clk = ~clk;

    hitrx_rollback dut_i (
        .clk       (clk),
        .rst       (rst),
        .ser_i     (ser_i),
        .rd_en_i   (rd_en_i),
        .rd_word_o (rd_word_o),
        .empty_o   (empty_o),
        .eoe_o     (eoe_o),
        .ovf_err_o (ovf_err_o)
    );

    always @(negedge clk) begin
        if (!rst && eoe_o) eoe_seen++;
    end

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [24:0] mk(input logic [3:0] t, input logic [7:0] r, input logic [4:0] c, input logic [7:0] o);
        return {t, r, c, o};
    endfunction

    function automatic logic [24:0] rnd_hit();
        logic [7:0] r = 8'($urandom % 256);
        logic [4:0] c = 5'($urandom % 32);
        if (r == 8'hFF && c == 5'h1F) c = 5'h00;
        return mk(4'($urandom % 16), r, c, 8'($urandom % 256));
    endfunction

    function automatic logic [24:0] rnd_marker();
        return mk(4'($urandom % 16), 8'hFF, 5'h1F, 8'($urandom % 256));
    endfunction

    task automatic model_rec(input logic [24:0] w);
        logic is_m = (w[20:13] == 8'hFF) && (w[12:8] == 5'h1F);
        if (m_drop && !is_m) return;
        if (cq.size() + pq.size() == DEPTH - 1) begin
            pq.delete();
            m_ovf  = 1'b1;
            m_drop = !is_m;
        end else begin
            m_drop = 1'b0;
            pq.push_back(w);
            if (is_m) begin
                foreach (pq[i]) cq.push_back(pq[i]);
                pq.delete();
                m_eoe++;
            end
        end
    endtask

    task automatic send_rec(input logic [24:0] w, input int gap);
        model_rec(w);
        @(negedge clk) ser_i = 1'b1;
        for (int i = 24; i >= 0; i--) begin
            @(negedge clk) ser_i = w[i];
        end
        if (gap > 0) begin
            @(negedge clk) ser_i = 1'b0;
            repeat (gap - 1) @(negedge clk);
        end
    endtask

    task automatic settle();
        @(negedge clk) ser_i = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic drain_n(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check(!empty_o, tag, {31'd0, empty_o}, 32'd0);
            check(rd_word_o == cq[0], tag, {7'd0, rd_word_o}, {7'd0, cq[0]});
            void'(cq.pop_front());
            rd_en_i = 1'b1;
        end
        @(negedge clk) rd_en_i = 1'b0;
    endtask

    task automatic batch_checks(input string tag);
        check(eoe_seen == m_eoe, {tag, " R3 eoe count"}, 32'(eoe_seen), 32'(m_eoe));
        check(ovf_err_o == m_ovf, {tag, " R8 ovf flag"}, {31'd0, ovf_err_o}, {31'd0, m_ovf});
        check(empty_o == (cq.size() == 0), {tag, " R4 empty"}, {31'd0, empty_o}, {31'd0, cq.size() == 0});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check(empty_o == 1'b1, "R9 empty after reset", {31'd0, empty_o}, 32'd1);
        check(eoe_o == 1'b0, "R9 eoe after reset", {31'd0, eoe_o}, 32'd0);
        check(ovf_err_o == 1'b0, "R9 ovf after reset", {31'd0, ovf_err_o}, 32'd0);

        // R1 R3: simple event, known field layout
        send_rec(mk(4'hA, 8'h12, 5'h03, 8'h5C), 3);
        send_rec(mk(4'h5, 8'hFF, 5'h1E, 8'h01), 2);
        send_rec(mk(4'hA, 8'hFF, 5'h1F, 8'h00), 1);
        settle();
        check(rd_word_o == 25'h1424_35C, "R1 first word layout", {7'd0, rd_word_o}, 32'h01424_35C);
        batch_checks("directed1");
        drain_n(3, "R1 R3 drain");
        check(empty_o == 1'b1, "R4 empty after drain", {31'd0, empty_o}, 32'd1);

        // R4 R5: partial event invisible, reads while empty ignored
        send_rec(rnd_hit(), 1);
        send_rec(rnd_hit(), 1);
        settle();
        check(empty_o == 1'b1, "R4 partial event hidden", {31'd0, empty_o}, 32'd1);
        @(negedge clk) rd_en_i = 1'b1;
        repeat (3) @(negedge clk);
        rd_en_i = 1'b0;
        send_rec(rnd_marker(), 1);
        settle();
        batch_checks("R5 read-while-empty");
        drain_n(3, "R5 order after empty reads");

        // R2: back-to-back records with no idle bit
        send_rec(rnd_hit(), 0);
        send_rec(rnd_hit(), 0);
        send_rec(rnd_hit(), 0);
        send_rec(rnd_marker(), 0);
        settle();
        batch_checks("R2 back-to-back");
        drain_n(cq.size(), "R2 drain");

        // R6: exactly 31 words, no overflow
        for (int i = 0; i < 30; i++) send_rec(rnd_hit(), 0);
        send_rec(rnd_marker(), 1);
        settle();
        check(ovf_err_o == 1'b0, "R6 31 words no error", {31'd0, ovf_err_o}, 32'd0);
        batch_checks("R6 fill");
        drain_n(31, "R6 drain full ring");

        // R7 R8: overflow inside second event
        for (int i = 0; i < 10; i++) send_rec(rnd_hit(), 1);
        send_rec(rnd_marker(), 1);
        for (int i = 0; i < 25; i++) send_rec(rnd_hit(), 0);
        send_rec(rnd_marker(), 1);
        settle();
        check(ovf_err_o == 1'b1, "R7 overflow raised", {31'd0, ovf_err_o}, 32'd1);
        check(cq.size() == 12, "R7 model keeps first event plus marker", 32'(cq.size()), 32'd12);
        batch_checks("R7 overflow");
        drain_n(cq.size(), "R7 rollback contents");

        // random mix with partial drains
        for (int round = 0; round < 40; round++) begin
            int nev = 1 + int'($urandom % 4);
            for (int e = 0; e < nev; e++) begin
                int nh = int'($urandom % 13);
                for (int h = 0; h < nh; h++) send_rec(rnd_hit(), int'($urandom % 4));
                send_rec(rnd_marker(), int'($urandom % 4));
            end
            settle();
            batch_checks("random R6 R7");
            if ($urandom % 2 == 0) drain_n(cq.size(), "random R5 full drain");
            else drain_n(int'($urandom % (cq.size() + 1)), "random R5 partial drain");
        end
        drain_n(cq.size(), "final R5 drain");
        check(empty_o == 1'b1, "R4 empty at end", {31'd0, empty_o}, 32'd1);

        // R8 R9: reset clears the sticky flag
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(ovf_err_o == 1'b0, "R8 cleared by reset", {31'd0, ovf_err_o}, 32'd0);
        check(empty_o == 1'b1, "R9 empty after second reset", {31'd0, empty_o}, 32'd1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule